// File: doc/BRIEF.md
# Programmable High/Low Clock Divider

This block divides a reference clock using two separately programmed counts, one for the high phase and one for the low phase, so both the output period and the duty cycle are set by software. A small register file accessed with a write strobe and an address holds the divider configuration (enable, high count, low count) and, when the channel has one, a gate bit. With the divider enabled, the output is a registered divided clock. With it disabled, the reference clock passes straight through. A status port reports the divide ratio that is in effect.

Reprogramming is safe. New configuration values are adopted only at the end of a complete low phase, so a pulse is never cut short. Gate changes are applied only while the divided clock is low or falling. A build-time option removes the gate entirely, and that channel is then always on.

Top module: `hl_clkdiv`

## Requirements
- R1: While and after a synchronous active-high reset, `clk_o` is low, `ratio_o` is 1, and both registers read 0. A channel built without a gate reads 1 from its gate register.
- R2: With the divider disabled and the gate set, `clk_o` equals `clk_i` and `ratio_o` is 1.
- R3: With the divider enabled, `clk_o` is high for H+1 and low for L+1 reference cycles. `ratio_o` equals H+L+2.
- R4: H=0 and L=0 give a divide-by-2 output at 50% duty, and `ratio_o` is 2.
- R5: The configuration register is at address 0. Bit 0 is the enable, bits 15:8 are H and bits 23:16 are L (defaults). It reads back the last written field values, and all other bits read 0. The gate register is at address 1, bit 0.
- R6: A clear gate forces `clk_o` low. A set gate lets the clock through.
- R7: New enable, H and L values take effect only after the last cycle of a complete low phase. Until then, `ratio_o` and the output keep the old setting.
- R8: A gate change never shortens or splits a high pulse of the divided clock.
- R9: A channel built without a gate is always enabled. Writes to its gate register have no effect, and it reads 1.
- R10: Clearing the enable while dividing switches to bypass only at the end of a complete low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 configuration, 1 gate |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` (combinational) |
| clk_o | output | 1 | Divided or bypassed, gated clock |
| ratio_o | output | max(HI_W,LO_W)+2 | Divide ratio in effect (1 in bypass) |

## Verification
The bench builds two instances on the same bus. The first uses the defaults: 8-bit fields and a gate present. Against a reference model it exercises bypass, several duty settings, divide-by-2, mid-pulse reprogramming and dense gate toggling. The second instance has 4-bit fields and no gate. It makes the always-on path reachable, and it shows that the field widths and the ratio width follow the parameters while the field positions stay unchanged.

// File: rtl/hl_clkdiv_pkg.sv
package hl_clkdiv_pkg;
   localparam logic ADDR_CFG  = 1'b0;
   localparam logic ADDR_GATE = 1'b1;

   function automatic int max_i(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // true when [a_pos, a_pos+a_w) and [b_pos, b_pos+b_w) share a bit
   function automatic bit spans_overlap(input int a_pos, input int a_w,
                                        input int b_pos, input int b_w);
      return (a_pos < b_pos + b_w) && (b_pos < a_pos + a_w);
   endfunction
endpackage

// File: rtl/hl_cfg_regs.sv
module hl_cfg_regs
   import hl_clkdiv_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int HI_W     = 8,
   parameter int LO_W     = 8,
   parameter int EN_POS   = 0,
   parameter int HI_POS   = 8,
   parameter int LO_POS   = 16,
   parameter bit HAS_GATE = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wr_i,
   input  logic              addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              sh_en_o,
   output logic [HI_W-1:0]   sh_hi_o,
   output logic [LO_W-1:0]   sh_lo_o,
   output logic              sh_gate_o
);
   logic            en_q;
   logic [HI_W-1:0] hi_q;
   logic [LO_W-1:0] lo_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         en_q <= 1'b0;
         hi_q <= '0;
         lo_q <= '0;
      end else if (wr_i && addr_i == ADDR_CFG) begin
         en_q <= wdata_i[EN_POS];
         hi_q <= wdata_i[HI_POS +: HI_W];
         lo_q <= wdata_i[LO_POS +: LO_W];
      end
   end

   generate
      if (HAS_GATE) begin : g_gate
         logic gate_q;
         always_ff @(posedge clk_i) begin
            if (rst_i)
               gate_q <= 1'b0;
            else if (wr_i && addr_i == ADDR_GATE)
               gate_q <= wdata_i[0];
         end
         assign sh_gate_o = gate_q;
      end else begin : g_no_gate
         assign sh_gate_o = 1'b1;
      end
   endgenerate

   // write data bits outside the fields are dropped on purpose
   logic unused_wdata;
   assign unused_wdata = ^wdata_i;

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_CFG) begin
         rdata_o[EN_POS]           = en_q;
         rdata_o[HI_POS +: HI_W]   = hi_q;
         rdata_o[LO_POS +: LO_W]   = lo_q;
      end else begin
         rdata_o[0] = sh_gate_o;
      end
   end

   assign sh_en_o = en_q;
   assign sh_hi_o = hi_q;
   assign sh_lo_o = lo_q;
endmodule

// File: rtl/hl_phase_cnt.sv
module hl_phase_cnt
   import hl_clkdiv_pkg::*;
#(
   parameter int HI_W = 8,
   parameter int LO_W = 8
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            sh_en_i,
   input  logic [HI_W-1:0] sh_hi_i,
   input  logic [LO_W-1:0] sh_lo_i,
   input  logic            sh_gate_i,
   output logic            act_en_o,
   output logic [HI_W-1:0] act_hi_o,
   output logic [LO_W-1:0] act_lo_o,
   output logic            div_o,
   output logic            gate_o
);
   localparam int CNT_W = max_i(HI_W, LO_W);

   logic             act_en_q;
   logic [HI_W-1:0]  act_hi_q;
   logic [LO_W-1:0]  act_lo_q;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             div_q, div_d;
   logic             gate_q;
   logic             low_done, load;

   // last cycle of a full low phase, or idle in bypass
   assign low_done = !div_q && (cnt_q == '0);
   assign load     = !act_en_q || low_done;

   always_comb begin
      div_d = div_q;
      cnt_d = cnt_q;
      if (load) begin
         div_d = sh_en_i;
         cnt_d = sh_en_i ? CNT_W'(sh_hi_i) : CNT_W'(sh_lo_i);
      end else if (cnt_q == '0) begin
         div_d = 1'b0;
         cnt_d = CNT_W'(act_lo_q);
      end else begin
         cnt_d = cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         act_en_q <= 1'b0;
         act_hi_q <= '0;
         act_lo_q <= '0;
         div_q    <= 1'b0;
         cnt_q    <= '0;
         gate_q   <= 1'b0;
      end else begin
         if (load) begin
            act_en_q <= sh_en_i;
            act_hi_q <= sh_hi_i;
            act_lo_q <= sh_lo_i;
         end
         div_q <= div_d;
         cnt_q <= cnt_d;
         // a high pulse that continues across this edge keeps its gate
         if (!div_q || !div_d)
            gate_q <= sh_gate_i;
      end
   end

   assign act_en_o = act_en_q;
   assign act_hi_o = act_hi_q;
   assign act_lo_o = act_lo_q;
   assign div_o    = div_q;
   assign gate_o   = gate_q;
endmodule

// File: rtl/hl_clkdiv.sv
module hl_clkdiv
   import hl_clkdiv_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int HI_W     = 8,
   parameter int LO_W     = 8,
   parameter int EN_POS   = 0,
   parameter int HI_POS   = 8,
   parameter int LO_POS   = 16,
   parameter bit HAS_GATE = 1'b1,
   localparam int RAT_W   = max_i(HI_W, LO_W) + 2
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wr_i,
   input  logic              addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              clk_o,
   output logic [RAT_W-1:0]  ratio_o
);
   generate
      if (HI_W < 1 || LO_W < 1) begin : g_bad_width
         $error("hl_clkdiv: field widths must be at least 1");
      end
      if (HI_POS + HI_W > DATA_W || LO_POS + LO_W > DATA_W || EN_POS >= DATA_W) begin : g_bad_fit
         $error("hl_clkdiv: a field does not fit in DATA_W");
      end
      if (spans_overlap(HI_POS, HI_W, LO_POS, LO_W) ||
          spans_overlap(EN_POS, 1, HI_POS, HI_W) ||
          spans_overlap(EN_POS, 1, LO_POS, LO_W)) begin : g_bad_overlap
         $error("hl_clkdiv: configuration fields overlap");
      end
   endgenerate

   logic            sh_en, sh_gate;
   logic [HI_W-1:0] sh_hi, act_hi;
   logic [LO_W-1:0] sh_lo, act_lo;
   logic            act_en, div_q, gate_q;

   hl_cfg_regs #(
      .DATA_W(DATA_W), .HI_W(HI_W), .LO_W(LO_W),
      .EN_POS(EN_POS), .HI_POS(HI_POS), .LO_POS(LO_POS),
      .HAS_GATE(HAS_GATE)
   ) u_regs (
      .clk_i(clk_i), .rst_i(rst_i), .wr_i(wr_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .rdata_o(rdata_o),
      .sh_en_o(sh_en), .sh_hi_o(sh_hi), .sh_lo_o(sh_lo), .sh_gate_o(sh_gate)
   );

   hl_phase_cnt #(.HI_W(HI_W), .LO_W(LO_W)) u_cnt (
      .clk_i(clk_i), .rst_i(rst_i),
      .sh_en_i(sh_en), .sh_hi_i(sh_hi), .sh_lo_i(sh_lo), .sh_gate_i(sh_gate),
      .act_en_o(act_en), .act_hi_o(act_hi), .act_lo_o(act_lo),
      .div_o(div_q), .gate_o(gate_q)
   );

   assign clk_o   = act_en ? (div_q & gate_q) : (clk_i & gate_q);
   assign ratio_o = act_en ? (RAT_W'(act_hi) + RAT_W'(act_lo) + RAT_W'(2))
                           : RAT_W'(1);
endmodule

// File: rtl/hl_clkdiv_chk.sv
module hl_clkdiv_chk #(
   parameter int HI_W  = 8,
   parameter int LO_W  = 8,
   parameter int CNT_W = 8
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             div_q,
   input logic             act_en_q,
   input logic [HI_W-1:0]  act_hi_q,
   input logic [LO_W-1:0]  act_lo_q,
   input logic [CNT_W-1:0] cnt_q,
   input logic             gate_q
);
   p_reset_low_r1: assert property (@(posedge clk_i)
      rst_i |=> (!div_q && !act_en_q && !gate_q));

   p_bypass_idle_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      !act_en_q |-> !div_q);

   p_high_len_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(div_q) |-> (cnt_q == CNT_W'(act_hi_q)));

   p_low_len_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(div_q) |-> (cnt_q == CNT_W'(act_lo_q)));

   p_cfg_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (act_en_q && $past(act_en_q) && !($past(!div_q) && $past(cnt_q) == '0))
      |-> ($stable(act_hi_q) && $stable(act_lo_q)));

   p_gate_in_high_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      (div_q && $past(div_q)) |-> $stable(gate_q));

   p_disable_at_low_end_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(act_en_q) |-> ($past(!div_q) && $past(cnt_q) == '0));
endmodule

bind hl_phase_cnt hl_clkdiv_chk #(.HI_W(HI_W), .LO_W(LO_W), .CNT_W(CNT_W)) u_chk (
   .clk_i(clk_i), .rst_i(rst_i), .div_q(div_q), .act_en_q(act_en_q),
   .act_hi_q(act_hi_q), .act_lo_q(act_lo_q), .cnt_q(cnt_q), .gate_q(gate_q)
);

// File: tb/test_hl_clkdiv.sv
module test_hl_clkdiv;
   localparam int CLK_P = 20;
   localparam int DW    = 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr = 1'b0;
   logic          addr = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata, rdata_ng;
   logic          clk_o, clk_o_ng;
   logic [9:0]    ratio;
   logic [5:0]    ratio_ng;

   int total = 0;
   int bad = 0;
   string cur_req = "R2";
   bit finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   hl_clkdiv i_hl_clkdiv (
      .clk_i(clk), .rst_i(rst), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rdata), .clk_o(clk_o), .ratio_o(ratio)
   );

   hl_clkdiv #(.HI_W(4), .LO_W(4), .HAS_GATE(1'b0)) i_hl_clkdiv_ng (
      .clk_i(clk), .rst_i(rst), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rdata_ng), .clk_o(clk_o_ng), .ratio_o(ratio_ng)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference: position inside the period, not a down-counter
   int  sh_en = 0, sh_h = 0, sh_l = 0, sh_g = 0;
   int  m_en = 0, m_h = 0, m_l = 0, m_pos = 0, m_gate = 0;
   bit  cur_high, nxt_high;

   always @(posedge clk) begin
      if (rst) begin
         m_en = 0; m_h = 0; m_l = 0; m_pos = 0; m_gate = 0;
         sh_en = 0; sh_h = 0; sh_l = 0; sh_g = 0;
      end else begin
         cur_high = (m_en != 0) && (m_pos <= m_h);
         if (m_en == 0) begin
            m_en = sh_en; m_h = sh_h; m_l = sh_l; m_pos = 0;
         end else begin
            m_pos++;
            if (m_pos == m_h + m_l + 2) begin
               m_en = sh_en; m_h = sh_h; m_l = sh_l; m_pos = 0;
            end
         end
         nxt_high = (m_en != 0) && (m_pos <= m_h);
         if (!(cur_high && nxt_high)) m_gate = sh_g;
         if (wr) begin
            if (addr == 1'b0) begin
               sh_en = int'(wdata[0]);
               sh_h  = int'(wdata[15:8]);
               sh_l  = int'(wdata[23:16]);
            end else begin
               sh_g = int'(wdata[0]);
            end
         end
      end
   end

   // per-cycle comparison, away from the edges
   always @(posedge clk) begin
      if (!rst && !finished) begin
         #(CLK_P/4);
         if (m_en != 0) begin
            check(clk_o == ((m_pos <= m_h) && m_gate != 0), cur_req, clk_o,
                  (m_pos <= m_h) && m_gate != 0);
            check(ratio == 10'(m_h + m_l + 2), cur_req, ratio, m_h + m_l + 2);
         end else begin
            check(clk_o == (m_gate != 0), cur_req, clk_o, m_gate);
            check(ratio == 10'd1, cur_req, ratio, 1);
            #(CLK_P/2);
            check(clk_o == 1'b0, cur_req, clk_o, 0);
         end
      end
   end

   task automatic write_reg(input logic a, input logic [DW-1:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   function automatic logic [DW-1:0] cfg(input int en, input int h, input int l);
      return DW'(en & 1) | (DW'(h & 8'hff) << 8) | (DW'(l & 8'hff) << 16);
   endfunction

   task automatic wait_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(CLK_P * 200000);
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state while reset is still held
      check(clk_o == 1'b0, "R1", clk_o, 0);
      check(ratio == 10'd1, "R1", ratio, 1);
      addr = 1'b0; #1;
      check(rdata == '0, "R1", rdata, 0);
      addr = 1'b1; #1;
      check(rdata == '0, "R1", rdata, 0);
      check(rdata_ng == 32'd1, "R1", rdata_ng, 1);
      @(negedge clk);
      rst = 1'b0;

      cur_req = "R2";
      write_reg(1'b1, 32'd1);
      wait_cycles(10);

      cur_req = "R5";
      write_reg(1'b0, 32'hA5_3C_5A_FE);
      addr = 1'b0; #1;
      check(rdata == 32'h00_3C_5A_00, "R5", rdata, 32'h00_3C_5A_00);
      addr = 1'b1; #1;
      check(rdata == 32'd1, "R5", rdata, 1);
      wait_cycles(4);

      cur_req = "R3";
      write_reg(1'b0, cfg(1, 2, 4));
      wait_cycles(40);
      check(ratio == 10'd8, "R3", ratio, 8);
      write_reg(1'b0, cfg(1, 6, 1));
      wait_cycles(40);
      check(ratio == 10'd9, "R3", ratio, 9);

      cur_req = "R4";
      write_reg(1'b0, cfg(1, 0, 0));
      wait_cycles(20);
      check(ratio == 10'd2, "R4", ratio, 2);

      cur_req = "R7";
      write_reg(1'b0, cfg(1, 3, 5));
      wait_cycles(30);
      while (clk_o !== 1'b1) @(negedge clk);
      write_reg(1'b0, cfg(1, 1, 1));
      check(ratio == 10'd10, "R7", ratio, 10);
      wait_cycles(30);
      check(ratio == 10'd4, "R7", ratio, 4);

      cur_req = "R6";
      write_reg(1'b0, cfg(1, 2, 2));
      write_reg(1'b1, 32'd0);
      wait_cycles(20);
      write_reg(1'b1, 32'd1);
      wait_cycles(20);

      cur_req = "R8";
      write_reg(1'b0, cfg(1, 5, 5));
      for (int i = 0; i < 40; i++) begin
         write_reg(1'b1, 32'(i % 2));
         wait_cycles(i % 3);
      end
      write_reg(1'b1, 32'd1);
      wait_cycles(15);

      cur_req = "R10";
      write_reg(1'b0, cfg(0, 4, 7));
      wait_cycles(30);
      check(ratio == 10'd1, "R10", ratio, 1);

      // R9: gate-less channel ignores a gate clear
      write_reg(1'b1, 32'd0);
      addr = 1'b1; #1;
      check(rdata_ng == 32'd1, "R9", rdata_ng, 1);
      @(posedge clk); #(CLK_P/4);
      check(clk_o_ng == 1'b1, "R9", clk_o_ng, 1);
      #(CLK_P/2);
      check(clk_o_ng == 1'b0, "R9", clk_o_ng, 0);
      wait_cycles(4);

      finished = 1'b1;
      #(CLK_P);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule